// File: doc/BRIEF.md
# Serially Programmed Clock Fan-out Gate Bank

This block takes one source clock and hands out eighteen gated copies of it. Each copy has its own enable bit. A write-only two-wire serial slave with a fixed 7-bit device address sets the enable bits. The serial lines are oversampled on a separate system clock. The slave detects start and stop conditions and matches the address. It acknowledges by pulling the data line low, and it assembles the data bytes. Each completed byte goes into one enable slice.

The bytes of a transfer fill the enable slices in order, starting from slice zero. There is no register pointer. Each enable bit crosses into the source-clock domain and is retimed on the falling edge of that clock. An AND gate then forms each output, so a copy only switches on or off while the source clock is low. A dedicated drive-enable input turns off the output-enable of every copy at once, which puts all eighteen outputs in high impedance.

Top module: `clkgate_bank`

## Requirements
- R1: The slave responds to address 1101001 (bits 6 to 0) followed by a write bit of 0. It acknowledges the address, and every data byte after it, by pulling SDA low during the ninth SCL clock.
- R2: If the address differs, or the read/write bit is 1, the slave does not acknowledge and no enable bit changes.
- R3: The first data byte of a transfer sets outputs 7 to 0. Bit n (n=0 is the least significant bit) controls output n, and bits arrive most significant bit first. A 1 enables the output and a 0 disables it.
- R4: The second data byte sets outputs 15 to 8. Bit n controls output 8+n.
- R5: In the third data byte, bit 7 controls output 17 and bit 6 controls output 16. Bits 5 to 0 have no effect.
- R6: Data bytes after the third one in the same transfer are acknowledged and change nothing.
- R7: After reset, all eighteen enable bits are 1.
- R8: An enable bit changes only once its byte has been fully received and acknowledged. A byte cut short by a stop condition changes nothing.
- R9: With drive_en low, every clk_oe bit is 0. With drive_en high, every clk_oe bit is 1, and each enabled clk_out follows src_clk.
- R10: A disabled clk_out is held low. Enable changes take effect only while src_clk is low, so a high phase of clk_out is never cut short or started late.
- R11: A repeated start ends the byte sequence. The next write transfer begins again at the first data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line (wired level) |
| sda_pull | output | 1 | 1 pulls the serial data line low (acknowledge) |
| src_clk | input | 1 | Clock that is fanned out |
| drive_en | input | 1 | 1 lets the outputs drive; 0 puts all of them in high impedance |
| clk_out | output | 18 | Gated copies of src_clk, bit i is output i |
| clk_oe | output | 18 | Output-enable of each copy |

## Verification
Two situations are the hardest to reach from the ports. The first is a byte boundary that never completes. The bench master sends only part of a data byte and then issues a stop, and it also issues a repeated start straight after an acknowledge. In both cases it checks that slice zero holds only the fully acknowledged values. The second is an enable change that lands while src_clk is high. src_clk runs unrelated to the serial timing, so commits fall at varying phases. A monitor samples every output twice in each high phase and reports any change inside one phase.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        SL_IDLE     = 3'd0,
        SL_ADDR     = 3'd1,
        SL_ADDR_ACK = 3'd2,
        SL_DATA     = 3'd3,
        SL_DATA_ACK = 3'd4
    } slave_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_now;

    assign scl_now = sync_q.scl_sh[STAGES-1];
    assign sda_s   = sync_q.sda_sh[STAGES-1];

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_raw};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_raw};
        sync_d.scl_prev = scl_now;
        sync_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_rise  = scl_now & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_now & sync_q.scl_prev;
    assign start_det = scl_now & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_now & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
    import clkgate_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'b1101001,
    parameter int unsigned NUM_BYTES = 3,
    parameter int unsigned IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
    localparam logic [3:0]        LAST_BIT = 4'(BYTE_W);

    typedef struct packed {
        slave_state_t      state;
        logic [BYTE_W-1:0] shreg;
        logic [3:0]        bitcnt;
        logic [IDX_W-1:0]  byte_idx;
        logic              pull;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } slv_t;

    slv_t slv_d, slv_q;

    always_comb begin
        slv_d       = slv_q;
        slv_d.wr_en = 1'b0;
        if (start_det) begin
            slv_d.state    = SL_ADDR;
            slv_d.bitcnt   = '0;
            slv_d.byte_idx = '0;
            slv_d.pull     = 1'b0;
        end else if (stop_det) begin
            slv_d.state = SL_IDLE;
            slv_d.pull  = 1'b0;
        end else begin
            unique case (slv_q.state)
                SL_ADDR, SL_DATA: begin
                    if (scl_rise) begin
                        slv_d.shreg  = {slv_q.shreg[BYTE_W-2:0], sda_s};
                        slv_d.bitcnt = slv_q.bitcnt + 4'd1;
                    end else if (scl_fall && slv_q.bitcnt == LAST_BIT) begin
                        slv_d.bitcnt = '0;
                        if (slv_q.state == SL_DATA) begin
                            slv_d.state = SL_DATA_ACK;
                            slv_d.pull  = 1'b1;
                        end else if (slv_q.shreg == ADDR_WR) begin
                            slv_d.state = SL_ADDR_ACK;
                            slv_d.pull  = 1'b1;
                        end else begin
                            slv_d.state = SL_IDLE;
                        end
                    end
                end
                SL_ADDR_ACK: begin
                    if (scl_fall) begin
                        slv_d.pull   = 1'b0;
                        slv_d.state  = SL_DATA;
                        slv_d.bitcnt = '0;
                    end
                end
                SL_DATA_ACK: begin
                    if (scl_fall) begin
                        slv_d.pull   = 1'b0;
                        slv_d.state  = SL_DATA;
                        slv_d.bitcnt = '0;
                        if (slv_q.byte_idx < IDX_W'(NUM_BYTES)) begin
                            slv_d.wr_en    = 1'b1;
                            slv_d.wr_idx   = slv_q.byte_idx;
                            slv_d.wr_data  = slv_q.shreg;
                            slv_d.byte_idx = slv_q.byte_idx + 1'b1;
                        end
                    end
                end
                default: begin
                    slv_d.state = SL_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q <= '0;
        end else begin
            slv_q <= slv_d;
        end
    end

    assign sda_pull = slv_q.pull;
    assign wr_en    = slv_q.wr_en;
    assign wr_idx   = slv_q.wr_idx;
    assign wr_data  = slv_q.wr_data;

    // R1
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_q.pull && !scl_fall && !start_det && !stop_det) |=> slv_q.pull)
        else $error("acknowledge released before SCL fell");

    // R8
    commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_q.wr_en |-> $past(slv_q.pull))
        else $error("byte committed without a preceding acknowledge");

endmodule

// File: rtl/en_reg_bank.sv
module en_reg_bank
    import clkgate_pkg::*;
#(
    parameter int unsigned N_OUT     = 18,
    parameter int unsigned NUM_BYTES = (N_OUT + BYTE_W - 1) / BYTE_W,
    parameter int unsigned IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [N_OUT-1:0]  en
);

    typedef struct packed {
        logic [N_OUT-1:0] en;
    } bank_t;

    bank_t            bank_d, bank_q;
    logic [N_OUT-1:0] hit;
    logic [N_OUT-1:0] val;

    for (genvar i = 0; i < N_OUT; i++) begin : g_map
        localparam int unsigned SLICE = i / BYTE_W;
        localparam int unsigned POS   = i % BYTE_W;
        localparam int unsigned LEFT  = N_OUT - BYTE_W * SLICE;
        localparam int unsigned WID   = (LEFT < BYTE_W) ? LEFT : BYTE_W;
        localparam int unsigned SRC   = BYTE_W - WID + POS;
        assign hit[i] = wr_en && (wr_idx == IDX_W'(SLICE));
        assign val[i] = wr_data[SRC];
    end

    always_comb begin
        bank_d    = bank_q;
        bank_d.en = (bank_q.en & ~hit) | (val & hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en = bank_q.en;

    // R8
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q.en))
        else $error("enable bits moved without a byte commit");

    if (NUM_BYTES > 1) begin : g_last_chk
        // R5
        last_slice_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(NUM_BYTES - 1))
            |=> $stable(bank_q.en[BYTE_W*(NUM_BYTES-1)-1:0]))
            else $error("last byte touched a lower slice");
    end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic en_req,
    output logic gclk
);

    logic [STAGES-1:0] gate_d, gate_q;

    always_comb begin
        gate_d = {gate_q[STAGES-2:0], en_req};
    end

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '1;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gclk = src_clk & gate_q[STAGES-1];

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
    import clkgate_pkg::*;
#(
    parameter int unsigned N_OUT       = 18,
    parameter logic [6:0]  DEV_ADDR    = 7'b1101001,
    parameter int unsigned LINE_SYNC   = 2,
    parameter int unsigned GATE_SYNC   = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    input  logic             src_clk,
    input  logic             drive_en,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_oe
);

    localparam int unsigned NUM_BYTES = (N_OUT + BYTE_W - 1) / BYTE_W;
    localparam int unsigned IDX_W     = $clog2(NUM_BYTES + 1);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [N_OUT-1:0]  en;

    i2c_line_sync #(.STAGES(LINE_SYNC)) u_sync (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_slave #(
        .DEV_ADDR  (DEV_ADDR),
        .NUM_BYTES (NUM_BYTES),
        .IDX_W     (IDX_W)
    ) u_slave (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    en_reg_bank #(
        .N_OUT     (N_OUT),
        .NUM_BYTES (NUM_BYTES),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .en      (en)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_cell
        clk_gate_cell #(.STAGES(GATE_SYNC)) u_cell (
            .src_clk (src_clk),
            .rst_n   (rst_n),
            .en_req  (en[i]),
            .gclk    (clk_out[i])
        );
    end

    assign clk_oe = {N_OUT{drive_en}};

endmodule

// File: tb/test_clkgate_bank.sv
module test_clkgate_bank;

    localparam int NO = 18;
    localparam int Q  = 10;

    logic          sys_clk = 1'b0;
    logic          src_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          m_scl   = 1'b1;
    logic          m_sda_low = 1'b0;
    logic          drive_en = 1'b1;
    logic          sda_pull;
    logic          sda_line;
    logic [NO-1:0] clk_out;
    logic [NO-1:0] clk_oe;

    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc   = 0;
    int            glitch_cnt = 0;
    bit            settled = 1'b0;
    bit            mon_on  = 1'b0;
    string         cur_tag = "R7";
    logic [NO-1:0] exp_en = '1;
    logic [NO-1:0] prev_out = '0;
    logic          prev_src = 1'b0;
    logic [7:0]    byte_q[$];

    assign sda_line = ~(m_sda_low | sda_pull);

    always #10 sys_clk = ~sys_clk;
    initial begin
        #5;
        forever #40 src_clk = ~src_clk;
    end

    clkgate_bank i_clkgate_bank (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .src_clk  (src_clk),
        .drive_en (drive_en),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model: cycle-by-cycle comparison once the enables are settled
    always @(negedge sys_clk) begin
        if (rst_n && mon_on) begin
            if (prev_src && src_clk && drive_en) begin
                n_chk++;
                if (clk_out != prev_out) begin
                    glitch_cnt++;
                    n_bad++;
                    $display("FAIL R10 mid-high change act=%0h exp=%0h", clk_out, prev_out);
                end
            end
            if (settled) begin
                chk(clk_oe == {NO{drive_en}}, "R9 oe", 32'(clk_oe), 32'({NO{drive_en}}));
                chk(clk_out == (src_clk ? exp_en : '0), cur_tag, 32'(clk_out),
                    32'(src_clk ? exp_en : '0));
            end
        end
        prev_src = src_clk;
        prev_out = clk_out;
    end

    always @(posedge sys_clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wq();
        repeat (Q) @(posedge sys_clk);
        #1;
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0;     wq();
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b; wq();
        m_scl = 1'b1;   wq(); wq();
        m_scl = 1'b0;   wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1;     wq();
        acked = (sda_line == 1'b0);
        wq();
        m_scl = 1'b0;     wq();
    endtask

    task automatic apply_byte(input int idx, input logic [7:0] b);
        case (idx)
            0: exp_en[7:0]  = b;
            1: exp_en[15:8] = b;
            2: begin exp_en[17] = b[7]; exp_en[16] = b[6]; end
            default: ;
        endcase
    endtask

    task automatic settle(input string tag);
        repeat (40) @(posedge sys_clk);
        #1;
        cur_tag = tag;
        settled = 1'b1;
        repeat (12) @(posedge sys_clk);
        #1;
    endtask

    task automatic run_write(input logic [7:0] addr_byte, input bit exp_ack, input string tag);
        bit a;
        settled = 1'b0;
        i2c_start();
        send_byte(addr_byte, a);
        chk(a == exp_ack, {tag, " address ack"}, 32'(a), 32'(exp_ack));
        if (a) begin
            for (int k = 0; k < byte_q.size(); k++) begin
                send_byte(byte_q[k], a);
                chk(a == 1'b1, {tag, " data ack"}, 32'(a), 32'd1);
                apply_byte(k, byte_q[k]);
            end
        end
        i2c_stop();
        settle(tag);
    endtask

    initial begin
        bit a;
        repeat (5) @(posedge sys_clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R7: all enabled out of reset
        settle("R7");
        chk(sda_pull == 1'b0, "R7 no pull after reset", 32'(sda_pull), 32'd0);

        // R1 and R3: first byte maps bit n to output n
        byte_q = '{8'hA5};
        run_write(8'hD2, 1'b1, "R3");
        chk(exp_en == 18'h3FFA5, "R3 model", 32'(exp_en), 32'h3FFA5);

        // R4 and R5: three bytes, reserved low bits of byte 2 set
        byte_q = '{8'h0F, 8'h3C, 8'h7F};
        run_write(8'hD2, 1'b1, "R5");

        // R6: bytes past the third are acknowledged and discarded
        byte_q = '{8'hFF, 8'hFF, 8'hC0, 8'h00, 8'h00};
        run_write(8'hD2, 1'b1, "R6");
        chk(exp_en == '1, "R6 model", 32'(exp_en), 32'h3FFFF);

        // R2: wrong address, then read bit with the right address
        byte_q = '{8'h00};
        run_write(8'hD0, 1'b0, "R2");
        run_write(8'hD3, 1'b0, "R2");

        // R8: byte aborted by a stop after five bits
        settled = 1'b0;
        i2c_start();
        send_byte(8'hD2, a);
        chk(a == 1'b1, "R8 address ack", 32'(a), 32'd1);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        i2c_stop();
        settle("R8");

        // R11: repeated start restarts at byte 0
        settled = 1'b0;
        i2c_start();
        send_byte(8'hD2, a);
        send_byte(8'h11, a);
        apply_byte(0, 8'h11);
        i2c_start();
        send_byte(8'hD2, a);
        chk(a == 1'b1, "R11 address ack", 32'(a), 32'd1);
        send_byte(8'h22, a);
        apply_byte(0, 8'h22);
        send_byte(8'h33, a);
        apply_byte(1, 8'h33);
        i2c_stop();
        settle("R11");
        chk(exp_en == 18'h33322, "R11 model", 32'(exp_en), 32'h33322);

        // R9: drive enable low puts every output in high impedance
        @(posedge sys_clk); #1;
        drive_en = 1'b0;
        cur_tag = "R9";
        repeat (8) @(posedge sys_clk);
        #1;
        drive_en = 1'b1;
        repeat (8) @(posedge sys_clk);
        #1;

        // R10: disable and re-enable with commits at varying clock phases
        for (int p = 0; p < 6; p++) begin
            repeat (p + 1) @(posedge sys_clk);
            byte_q = '{8'(p * 37), 8'(~(p * 37))};
            run_write(8'hD2, 1'b1, "R10");
        end
        chk(glitch_cnt == 0, "R10 glitch count", 32'(glitch_cnt), 32'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule